// File: doc/BRIEF.md
# Module Power Control Slave

Every module on a shared power and fault management bus carries a small piece of logic that never loses power. This block is that logic. It watches the command bus, accepts only the commands that carry its own fixed strap address, and drives a power-enable output that switches the rest of the module on or off. The same bus serves to save power and to select between redundant units, and it is shared by all modules and brought out to an external connector.

Two masters can issue commands. The external master has priority; the onboard processor is the secondary master. When both strobe in the same cycle, the external command runs and the processor command is parked and runs on the first cycle with no external strobe. A Status command returns the power state and a health flag in the response slot one cycle after the command is executed. A discrete reset input puts the module back in its minimum-power configuration: essential modules stay on, all others go off.

Top module: `pcb_slave`

## Requirements
- R1: An On command (opcode 2'b01) executed with the module's strap address sets `pwr_en` to 1 on the clock edge that executes it.
- R2: An Off command (opcode 2'b10) executed with the module's strap address clears `pwr_en` to 0 on the clock edge that executes it.
- R3: A command whose address differs from the strap address, or whose opcode is 2'b00, leaves `pwr_en` unchanged and produces no status reply.
- R4: When `pri_stb` and `sec_stb` are both high in one cycle, the external command executes in that cycle, the processor command is held (`sec_wait` = 1) and executes on the first later cycle in which `pri_stb` is low.
- R5: A Status command (opcode 2'b11) to the strap address raises `sts_valid` for the one cycle after the executing edge, with `sts_pwr` equal to `pwr_en` before that edge, `sts_health` equal to `health_ok` at that edge, and `sts_to_sec` = 1 when the command came from the processor, 0 from the external master.
- R6: While `dis_rst` is high at a clock edge, `pwr_en` becomes the `ESSENTIAL` strap value, any held processor command is discarded, no status reply is produced, and commands in that cycle are ignored.
- R7: While `rst_n` is low, `pwr_en` equals the `ESSENTIAL` strap value and `sts_valid` and `sec_wait` are 0.
- R8: While `sec_wait` is high, a new `sec_stb` is ignored; the processor must repeat it after `sec_wait` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on logic |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dis_rst | input | 1 | Discrete reset to minimum-power configuration, active high, synchronous |
| pri_stb | input | 1 | External master command strobe |
| pri_addr | input | ADDR_W | External master target address |
| pri_op | input | 2 | External master opcode |
| sec_stb | input | 1 | Processor master command strobe |
| sec_addr | input | ADDR_W | Processor master target address |
| sec_op | input | 2 | Processor master opcode |
| health_ok | input | 1 | Module health flag reported by Status |
| pwr_en | output | 1 | Power enable for the switched part of the module |
| sec_wait | output | 1 | A processor command is parked behind the external master |
| sts_valid | output | 1 | Status reply slot |
| sts_pwr | output | 1 | Reported power state |
| sts_health | output | 1 | Reported health flag |
| sts_to_sec | output | 1 | Reply belongs to the processor (1) or external master (0) |

## Verification
The hardest situation to reach is a parked processor command that stays parked across several consecutive external strobes, meets a fresh processor strobe while waiting, and is then either executed or discarded by a discrete reset. Directed sequences build that collision and its exit paths, while long random runs with a high strobe density on both masters, a biased address mix that hits the strap address about half the time and rare discrete resets land in the same corners many times over, checked every cycle against a reference model in the bench.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   typedef enum logic [1:0] {
      OP_NOP  = 2'b00,
      OP_ON   = 2'b01,
      OP_OFF  = 2'b10,
      OP_STAT = 2'b11
   } pcb_op_e;

   localparam logic SRC_PRI = 1'b0;
   localparam logic SRC_SEC = 1'b1;
endpackage

// File: rtl/pcb_arbiter.sv
module pcb_arbiter #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_rst,
   input  logic              pri_stb,
   input  logic [ADDR_W-1:0] pri_addr,
   input  logic [1:0]        pri_op,
   input  logic              sec_stb,
   input  logic [ADDR_W-1:0] sec_addr,
   input  logic [1:0]        sec_op,
   output logic              cmd_vld,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [1:0]        cmd_op,
   output logic              cmd_src,
   output logic              pend_vld
);
   import pcb_pkg::*;

   logic [ADDR_W-1:0] pend_addr;
   logic [1:0]        pend_op;
   logic              gnt_pri, gnt_pend, gnt_sec;

   // fixed priority: external master, then parked command, then fresh processor strobe
   always_comb begin
      gnt_pri  = pri_stb;
      gnt_pend = !pri_stb && pend_vld;
      gnt_sec  = !pri_stb && !pend_vld && sec_stb;
      cmd_vld  = gnt_pri || gnt_pend || gnt_sec;
      cmd_src  = gnt_pri ? SRC_PRI : SRC_SEC;
      if (gnt_pri) begin
         cmd_addr = pri_addr;
         cmd_op   = pri_op;
      end else if (gnt_pend) begin
         cmd_addr = pend_addr;
         cmd_op   = pend_op;
      end else begin
         cmd_addr = sec_addr;
         cmd_op   = sec_op;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_op   <= 2'b00;
      end else if (dis_rst) begin
         pend_vld  <= 1'b0;
      end else if (pend_vld) begin
         if (!pri_stb) pend_vld <= 1'b0;
      end else if (pri_stb && sec_stb) begin
         pend_vld  <= 1'b1;
         pend_addr <= sec_addr;
         pend_op   <= sec_op;
      end
   end

   p_grant_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_pri, gnt_pend, gnt_sec}));
   p_park_on_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_stb && sec_stb && !pend_vld && !dis_rst) |=> pend_vld);
   p_park_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vld && pri_stb && !dis_rst) |=> (pend_vld && $stable(pend_addr) && $stable(pend_op)));
   p_dis_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_rst |=> !pend_vld);
endmodule

// File: rtl/pcb_decode.sv
module pcb_decode #(
   parameter int                ADDR_W  = 4,
   parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
   input  logic              cmd_vld,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [1:0]        cmd_op,
   output logic              hit_on,
   output logic              hit_off,
   output logic              hit_stat
);
   import pcb_pkg::*;

   logic [ADDR_W-1:0] bit_eq;
   logic              addr_hit;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
      assign bit_eq[i] = cmd_addr[i] ~^ MY_ADDR[i];
   end

   assign addr_hit = cmd_vld && (&bit_eq);

   always_comb begin
      hit_on   = addr_hit && (cmd_op == OP_ON);
      hit_off  = addr_hit && (cmd_op == OP_OFF);
      hit_stat = addr_hit && (cmd_op == OP_STAT);
   end

   always_comb begin
      a_decode_excl_r3: assert ($onehot0({hit_on, hit_off, hit_stat}));
   end
endmodule

// File: rtl/pcb_power.sv
module pcb_power #(
   parameter bit ESSENTIAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dis_rst,
   input  logic hit_on,
   input  logic hit_off,
   input  logic hit_stat,
   input  logic cmd_src,
   input  logic health_ok,
   output logic pwr_en,
   output logic sts_valid,
   output logic sts_pwr,
   output logic sts_health,
   output logic sts_to_sec
);
   localparam logic PWR_MIN = ESSENTIAL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_en     <= PWR_MIN;
         sts_valid  <= 1'b0;
         sts_pwr    <= 1'b0;
         sts_health <= 1'b0;
         sts_to_sec <= 1'b0;
      end else if (dis_rst) begin
         pwr_en     <= PWR_MIN;
         sts_valid  <= 1'b0;
      end else begin
         if (hit_on)       pwr_en <= 1'b1;
         else if (hit_off) pwr_en <= 1'b0;
         sts_valid <= hit_stat;
         if (hit_stat) begin
            sts_pwr    <= pwr_en;
            sts_health <= health_ok;
            sts_to_sec <= cmd_src;
         end
      end
   end

   p_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_on && !dis_rst) |=> pwr_en);
   p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_off && !dis_rst) |=> !pwr_en);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_on && !hit_off && !dis_rst) |=> $stable(pwr_en));
   p_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sts_valid |-> $past(hit_stat && !dis_rst));
   p_dis_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_rst |=> (pwr_en == PWR_MIN && !sts_valid));
endmodule

// File: rtl/pcb_slave.sv
module pcb_slave #(
   parameter int                ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] MY_ADDR   = 4'h5,
   parameter bit                ESSENTIAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_rst,
   input  logic              pri_stb,
   input  logic [ADDR_W-1:0] pri_addr,
   input  logic [1:0]        pri_op,
   input  logic              sec_stb,
   input  logic [ADDR_W-1:0] sec_addr,
   input  logic [1:0]        sec_op,
   input  logic              health_ok,
   output logic              pwr_en,
   output logic              sec_wait,
   output logic              sts_valid,
   output logic              sts_pwr,
   output logic              sts_health,
   output logic              sts_to_sec
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_width
      $error("pcb_slave: ADDR_W must lie in 1..16");
   end

   logic              cmd_vld, cmd_src;
   logic [ADDR_W-1:0] cmd_addr;
   logic [1:0]        cmd_op;
   logic              hit_on, hit_off, hit_stat;

   pcb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .dis_rst(dis_rst),
      .pri_stb(pri_stb), .pri_addr(pri_addr), .pri_op(pri_op),
      .sec_stb(sec_stb), .sec_addr(sec_addr), .sec_op(sec_op),
      .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_op(cmd_op),
      .cmd_src(cmd_src), .pend_vld(sec_wait)
   );

   pcb_decode #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_dec (
      .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_op(cmd_op),
      .hit_on(hit_on), .hit_off(hit_off), .hit_stat(hit_stat)
   );

   pcb_power #(.ESSENTIAL(ESSENTIAL)) u_pwr (
      .clk(clk), .rst_n(rst_n), .dis_rst(dis_rst),
      .hit_on(hit_on), .hit_off(hit_off), .hit_stat(hit_stat),
      .cmd_src(cmd_src), .health_ok(health_ok),
      .pwr_en(pwr_en), .sts_valid(sts_valid), .sts_pwr(sts_pwr),
      .sts_health(sts_health), .sts_to_sec(sts_to_sec)
   );

   p_sec_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_wait && !pri_stb && !dis_rst) |=> !sec_wait);
endmodule

// File: tb/tb_pcb_slave.sv
module tb_pcb_slave;
   localparam int          AW  = 4;
   localparam logic [3:0]  ME  = 4'h5;
   localparam bit          ESS = 1'b0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dis_rst = 1'b0;
   logic pri_stb = 1'b0, sec_stb = 1'b0, health_ok = 1'b1;
   logic [AW-1:0] pri_addr = '0, sec_addr = '0;
   logic [1:0] pri_op = 2'b00, sec_op = 2'b00;
   logic pwr_en, sec_wait, sts_valid, sts_pwr, sts_health, sts_to_sec;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   // reference model state
   logic m_pwr = ESS, m_pend = 1'b0, m_sv = 1'b0, m_sp = 1'b0, m_sh = 1'b0, m_ss = 1'b0;
   logic [AW-1:0] m_pa = '0;
   logic [1:0] m_po = 2'b00;

   always #10 clk = ~clk;

   pcb_slave #(.ADDR_W(AW), .MY_ADDR(ME), .ESSENTIAL(ESS)) dut (
      .clk(clk), .rst_n(rst_n), .dis_rst(dis_rst),
      .pri_stb(pri_stb), .pri_addr(pri_addr), .pri_op(pri_op),
      .sec_stb(sec_stb), .sec_addr(sec_addr), .sec_op(sec_op),
      .health_ok(health_ok), .pwr_en(pwr_en), .sec_wait(sec_wait),
      .sts_valid(sts_valid), .sts_pwr(sts_pwr), .sts_health(sts_health),
      .sts_to_sec(sts_to_sec)
   );

   function automatic bit hits(input logic [AW-1:0] a, input logic [1:0] op, input logic [1:0] want);
      return (a == ME) && (op == want);
   endfunction

   // next model state from the current inputs (R1..R8)
   task automatic model_step();
      logic v, src;
      logic [AW-1:0] a;
      logic [1:0] op;
      if (dis_rst) begin
         m_pwr = ESS; m_pend = 1'b0; m_sv = 1'b0;
         return;
      end
      v = 1'b1;
      if (pri_stb) begin a = pri_addr; op = pri_op; src = 1'b0; end
      else if (m_pend) begin a = m_pa; op = m_po; src = 1'b1; end
      else if (sec_stb) begin a = sec_addr; op = sec_op; src = 1'b1; end
      else begin a = '0; op = 2'b00; src = 1'b0; v = 1'b0; end
      // parking
      if (m_pend) begin
         if (!pri_stb) m_pend = 1'b0;
      end else if (pri_stb && sec_stb) begin
         m_pend = 1'b1; m_pa = sec_addr; m_po = sec_op;
      end
      m_sv = v && hits(a, op, 2'b11);
      if (m_sv) begin m_sp = m_pwr; m_sh = health_ok; m_ss = src; end
      if (v && hits(a, op, 2'b01)) m_pwr = 1'b1;
      else if (v && hits(a, op, 2'b10)) m_pwr = 1'b0;
   endtask

   task automatic check(input string tag);
      n_vec++;
      if (pwr_en !== m_pwr || sec_wait !== m_pend || sts_valid !== m_sv ||
          (m_sv && {sts_pwr, sts_health, sts_to_sec} !== {m_sp, m_sh, m_ss})) begin
         n_bad++;
         $display("FAIL %s cyc %0d: got pwr=%b wait=%b sv=%b sts=%b%b%b exp pwr=%b wait=%b sv=%b sts=%b%b%b",
                  tag, cyc, pwr_en, sec_wait, sts_valid, sts_pwr, sts_health, sts_to_sec,
                  m_pwr, m_pend, m_sv, m_sp, m_sh, m_ss);
      end
   endtask

   // one cycle: drive at negedge, let an edge pass, check at next negedge
   task automatic cycle(input string tag, input logic ps, input logic [AW-1:0] pa, input logic [1:0] po,
                        input logic ss, input logic [AW-1:0] sa, input logic [1:0] so,
                        input logic dr, input logic hk);
      pri_stb = ps; pri_addr = pa; pri_op = po;
      sec_stb = ss; sec_addr = sa; sec_op = so;
      dis_rst = dr; health_ok = hk;
      model_step();
      @(negedge clk);
      cyc++;
      check(tag);
   endtask

   task automatic idle(input string tag);
      cycle(tag, 0, '0, 2'b00, 0, '0, 2'b00, 0, 1);
   endtask

   initial begin
      #4_000_000;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1789;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R7");                       // reset state
      rst_n = 1'b1;
      idle("R7");
      // R1 / R2 / R3 directed
      cycle("R1", 1, ME, 2'b01, 0, '0, 2'b00, 0, 1);
      cycle("R3", 1, 4'h6, 2'b10, 0, '0, 2'b00, 0, 1);  // wrong address
      cycle("R3", 1, ME, 2'b00, 0, '0, 2'b00, 0, 1);    // NOP
      cycle("R3", 1, 4'h4, 2'b11, 0, '0, 2'b00, 0, 1);  // status elsewhere
      idle("R3");
      cycle("R5", 1, ME, 2'b11, 0, '0, 2'b00, 0, 0);
      idle("R5");
      cycle("R2", 1, ME, 2'b10, 0, '0, 2'b00, 0, 1);
      cycle("R5", 0, '0, 2'b00, 1, ME, 2'b11, 0, 1);    // processor status
      idle("R5");
      cycle("R1", 0, '0, 2'b00, 1, ME, 2'b01, 0, 1);    // processor on alone
      idle("R1");
      // R4: clash, external off wins, processor on parked
      cycle("R4", 1, ME, 2'b10, 1, ME, 2'b01, 0, 1);
      cycle("R4", 1, 4'h2, 2'b01, 0, '0, 2'b00, 0, 1);  // still parked
      cycle("R8", 1, 4'h2, 2'b01, 1, ME, 2'b10, 0, 1);  // fresh strobe dropped
      cycle("R8", 0, '0, 2'b00, 1, ME, 2'b11, 0, 1);    // parked on runs, fresh dropped
      idle("R4");
      idle("R8");
      // R6: discrete reset with parked command and power on
      cycle("R4", 1, ME, 2'b11, 1, ME, 2'b01, 0, 1);
      cycle("R6", 0, '0, 2'b00, 0, '0, 2'b00, 1, 1);
      idle("R6");
      cycle("R1", 1, ME, 2'b01, 0, '0, 2'b00, 0, 1);
      cycle("R6", 1, ME, 2'b01, 1, ME, 2'b11, 1, 1);    // commands ignored under dis_rst
      idle("R6");
      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] a1, a2;
         a1 = ($urandom_range(1, 0) == 1) ? ME : AW'($urandom);
         a2 = ($urandom_range(1, 0) == 1) ? ME : AW'($urandom);
         cycle("R4", ($urandom_range(2, 0) != 0), a1, 2'($urandom),
               ($urandom_range(1, 0) == 1), a2, 2'($urandom),
               ($urandom_range(63, 0) == 0), 1'($urandom));
      end
      // R7: asynchronous reset mid-run
      cycle("R1", 1, ME, 2'b01, 1, ME, 2'b10, 0, 1);
      rst_n = 1'b0;
      m_pwr = ESS; m_pend = 1'b0; m_sv = 1'b0;
      #1 check("R7");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R7");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule